// File: doc/BRIEF.md
# Successive-Approximation Conversion Controller

This block sequences one analog-to-digital conversion by binary search. It drives an N-bit trial code to an external DAC, and an external comparator reports whether that code is above the analog input. A start request loads the trial code with only the top bit set. After that, each clock cycle decides one bit: the bit under test is kept when the comparator reports that the trial is not too high, and cleared otherwise. In the same cycle the next lower bit is set for its own trial.

Every conversion takes exactly N decision cycles, whatever the input level. After the last decision, a one-cycle done pulse marks the parallel result. Each decided bit also appears on a serial output, most significant first, in the cycle after its decision. This lets a downstream consumer take the result bit by bit without a shift register of its own.

Top module: `sar_ctrl`

## Requirements
- R1: While rst_ni is low, busy_o, done_o, ser_valid_o, ser_bit_o, dac_code_o and result_o are all zero.
- R2: When start_i is high at a rising edge while busy_o is low, busy_o is high after that edge and dac_code_o holds only bit N-1 set.
- R3: At each decision edge, the bit under test becomes 1 if cmp_high_i was 0 and becomes 0 if cmp_high_i was 1, where cmp_high_i = 1 means the trial code is above the input. The bits above it are unchanged.
- R4: At each decision edge other than the last, the next lower bit of dac_code_o is set to 1. The bits below it stay 0.
- R5: The conversion lasts exactly N busy cycles, bits N-1 down to 0. done_o is high for exactly one cycle after the N-th decision, and busy_o falls in that same cycle.
- R6: In the done cycle, result_o equals the final code. For an ideal threshold comparator, that code is the integer input level. result_o holds its value until the next done pulse.
- R7: After each decision edge, ser_valid_o is high for one cycle and ser_bit_o carries the bit just decided, most significant first. ser_valid_o is low outside conversions.
- R8: A start_i pulse while busy_o is high is ignored: the running conversion keeps its timing and result, and no extra conversion follows.
- R9: A start request in the done cycle is accepted, so conversions can run back to back.
- R10: The width N is a parameter with a default of 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Conversion request, honoured only when idle |
| cmp_high_i | input | 1 | Comparator: 1 when the trial code is above the analog input |
| dac_code_o | output | N | Trial code driven to the DAC |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle pulse: result_o is new |
| result_o | output | N | Last completed conversion result |
| ser_bit_o | output | 1 | Bit decided at the previous edge |
| ser_valid_o | output | 1 | ser_bit_o is valid |

## Verification
The assertions assume that cmp_high_i settles within the cycle in which dac_code_o is presented and depends only on that code. The bench models the comparator as a combinational threshold against an input level, and changes that level only at the falling edge and only while the block is idle. start_i is driven at falling edges, so it has no settling issue. Random input levels with a fixed seed are combined with the extreme codes and the mid-scale codes, with back-to-back starts, and with start pulses injected during conversions.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_CONV = 1'b1
  } sar_state_e;
endpackage

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int N  = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          load_o,
  output logic          step_o,
  output logic          last_o,
  output logic [IW-1:0] idx_o
);
  import sar_pkg::*;

  sar_state_e    state_q;
  logic [IW-1:0] idx_q;

  assign load_o = start_i && (state_q == ST_IDLE);
  assign step_o = (state_q == ST_CONV);
  assign last_o = step_o && (idx_q == '0);
  assign idx_o  = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else if (load_o) begin
      state_q <= ST_CONV;
      idx_q   <= IW'(N - 1);
    end else if (last_o) begin
      state_q <= ST_IDLE;
    end else if (step_o) begin
      idx_q <= idx_q - 1'b1;
    end
  end

  // R8: busy start requests do not disturb the countdown
  a_r8_countdown: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o && !last_o |=> step_o && idx_o == $past(idx_o) - 1'b1);
  a_r2_load_msb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> step_o && idx_o == IW'(N - 1));
  a_r5_ends_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> !step_o);
endmodule

// File: rtl/sar_trial.sv
module sar_trial #(
  parameter int N  = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          step_i,
  input  logic          last_i,
  input  logic [IW-1:0] idx_i,
  input  logic          cmp_high_i,
  output logic [N-1:0]  code_q_o,
  output logic [N-1:0]  code_d_o
);
  logic [N-1:0] code_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    localparam bit INIT = (i == N - 1);
    logic hit, nxt;
    assign hit = (idx_i == IW'(i));
    if (i < N - 1) begin : g_lower
      assign nxt = !last_i && (idx_i == IW'(i + 1));
    end else begin : g_top
      assign nxt = 1'b0;
    end
    assign code_d_o[i] = load_i ? INIT :
                         !step_i ? code_q[i] :
                         hit ? !cmp_high_i :
                         nxt ? 1'b1 : code_q[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) code_q <= '0;
    else         code_q <= code_d_o;
  end

  assign code_q_o = code_q;

  a_r3_decide: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> code_q[$past(idx_i)] == !$past(cmp_high_i));
  a_r4_next_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !last_i |=> code_q[$past(idx_i) - 1'b1]);
  a_r2_msb_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> code_q == {1'b1, {(N-1){1'b0}}});
endmodule

// File: rtl/sar_out.sv
module sar_out #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  input  logic         last_i,
  input  logic         cmp_high_i,
  input  logic [N-1:0] code_d_i,
  input  logic [N-1:0] code_q_i,
  output logic         done_o,
  output logic [N-1:0] result_o,
  output logic         ser_bit_o,
  output logic         ser_valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o      <= 1'b0;
      result_o    <= '0;
      ser_bit_o   <= 1'b0;
      ser_valid_o <= 1'b0;
    end else begin
      done_o      <= last_i;
      ser_valid_o <= step_i;
      if (step_i) ser_bit_o <= !cmp_high_i;
      if (last_i) result_o  <= code_d_i;
    end
  end

  a_r5_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r6_result_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |=> $stable(result_o) || done_o);
  a_r6_result_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> result_o == code_q_i);
  a_r7_last_serial: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ser_valid_o && ser_bit_o == code_q_i[0]);
endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         cmp_high_i,
  output logic [N-1:0] dac_code_o,
  output logic         busy_o,
  output logic         done_o,
  output logic [N-1:0] result_o,
  output logic         ser_bit_o,
  output logic         ser_valid_o
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic          load, step, last;
  logic [IW-1:0] idx;
  logic [N-1:0]  code_q, code_d;

  sar_seq #(.N(N), .IW(IW)) u_seq (
    .clk_i, .rst_ni, .start_i,
    .load_o(load), .step_o(step), .last_o(last), .idx_o(idx)
  );

  sar_trial #(.N(N), .IW(IW)) u_trial (
    .clk_i, .rst_ni,
    .load_i(load), .step_i(step), .last_i(last), .idx_i(idx),
    .cmp_high_i, .code_q_o(code_q), .code_d_o(code_d)
  );

  sar_out #(.N(N)) u_out (
    .clk_i, .rst_ni,
    .step_i(step), .last_i(last), .cmp_high_i,
    .code_d_i(code_d), .code_q_i(code_q),
    .done_o, .result_o, .ser_bit_o, .ser_valid_o
  );

  assign dac_code_o = code_q;
  assign busy_o     = step;

  a_r5_busy_done_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));
  a_r7_valid_in_conv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_valid_o |-> busy_o || done_o);
endmodule

// File: tb/sar_ctrl_tb.sv
module sar_ctrl_tb_top;
  localparam int N       = 8;
  localparam int CLK_PER = 10;

  logic         clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [N-1:0] vin = '0;
  logic         cmp_high;
  logic [N-1:0] dac_code, result;
  logic         busy, done, ser_bit, ser_valid;
  int           n_chk = 0, n_bad = 0;

  always #(CLK_PER/2) clk = ~clk;
  assign cmp_high = (dac_code > vin);  // ideal threshold comparator

  sar_ctrl #(.N(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cmp_high_i(cmp_high),
    .dac_code_o(dac_code), .busy_o(busy), .done_o(done), .result_o(result),
    .ser_bit_o(ser_bit), .ser_valid_o(ser_valid)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] msb_only();
    return {1'b1, {(N-1){1'b0}}};
  endfunction

  // start at a falling edge; optionally poke start mid-conversion
  task automatic convert(input logic [N-1:0] v, input int poke_at);
    vin   = v;
    start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R2 busy", busy, 1);
    check(dac_code === msb_only(), "R2 msb trial", dac_code, msb_only());
    for (int k = 1; k <= N; k++) begin
      if (k == poke_at) start = 1'b1;
      @(posedge clk); @(negedge clk);
      start = 1'b0;
      check(ser_valid === 1'b1 && ser_bit === v[N-k], "R7 serial bit", ser_bit, v[N-k]);
      if (k < N) begin
        check(busy === 1'b1 && done === 1'b0, "R5 still busy", {busy, done}, 2'b10);
        check(dac_code[N-1 -: 1] === v[N-1], "R3 top bit kept", dac_code[N-1], v[N-1]);
        check(dac_code[N-k-1] === 1'b1, "R4 next trial bit", dac_code[N-k-1], 1);
      end else begin
        check(done === 1'b1 && busy === 1'b0, "R5 done pulse", {busy, done}, 2'b01);
        check(result === v, "R6 result", result, v);
        check(dac_code === v, "R3 final code", dac_code, v);
      end
    end
  endtask

  initial begin
    logic [N-1:0] held;
    void'($urandom(32'h5a17));
    #(CLK_PER*2 + 1);
    check(busy === 0 && done === 0 && ser_valid === 0 && ser_bit === 0 &&
          dac_code === 0 && result === 0, "R1 reset", {busy, done, dac_code}, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check(N == 8, "R10 width", N, 8);

    convert(8'h00, 0);
    convert(8'hFF, 0);   // R9 back to back
    convert(8'h80, 0);
    convert(8'h7F, 0);
    convert(8'h55, 3);   // R8 start while busy
    check(done === 1'b1, "R9 done cycle", done, 1);
    @(posedge clk); @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && ser_valid === 1'b0, "R8 no extra run",
          {busy, done, ser_valid}, 0);
    held = result;
    vin  = 8'h11;
    repeat (3) @(negedge clk);
    check(result === held && busy === 1'b0, "R6 result held", result, held);
    convert(8'hAA, N);   // R8 poke on last step
    @(posedge clk); @(negedge clk);
    check(busy === 1'b0, "R8 last-step poke ignored", busy, 0);

    for (int t = 0; t < 40; t++) begin
      convert(N'($urandom), ((t % 5) == 0) ? 1 + (t % N) : 0);
      if (t % 3 == 0) begin
        @(negedge clk);
        check(done === 1'b0 && ser_valid === 1'b0, "R7 idle serial", ser_valid, 0);
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PER * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=1 exp=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule